// File: doc/BRIEF.md
# Power-Fail Aware Reset Sequencer

This block turns two supply-monitor inputs into the chip's internal reset and an active-low reset output for the board. The power-on sense input marks that all supplies are valid. The power-good input gives early warning that a supply is about to collapse. Both inputs are synchronised to a free-running system clock. Every time window is a parameter counted in cycles of that clock.

A power-good low is a power-fail event only once it has lasted a qualification window. Shorter dips count as glitches and are dropped. On a real event the sequencer first asks the display device to park. It waits for an acknowledge, or for a timeout. It then enters a full internal reset. That reset is held while power-good stays low. It ends only after power-good has been high for a second qualification window. A one-cycle request from on-chip logic starts the same reset without the park step.

The board reset output has its own rules. It goes low at once, with no clock, whenever power-on sense is low. After power-up it stays low until software writes a release pulse. Once released, it follows each hardware reset event after a fixed delay. Every hardware-driven low period lasts at least a minimum width. Software can also force the output low at any time through a separate input.

Top module: `pwr_rst_seq`

## Requirements
- R1: While `pon_sense_i` is 0, `ext_rst_n_o` is 0 with no clock edge needed. `int_rst_o` is 1 and `park_req_o` is 0 in that state.
- R2: After `pon_sense_i` rises, `ext_rst_n_o` stays 0 until a one-cycle `sw_release_i` pulse arrives. The pulse takes effect two cycles after it is driven. The output also never rises earlier than WIDTH_CYC+2 cycles after `pon_sense_i` rises, and a release pulse that arrives earlier is remembered.
- R3: A low pulse on `pgood_i` shorter than PG_LO_CYC cycles has no effect: `park_req_o` stays 0, `int_rst_o` stays 0 and `ext_rst_n_o` stays 1. A low level lasting PG_LO_CYC cycles or more is a power-fail event.
- R4: On a power-fail event, `park_req_o` and `int_rst_o` both rise PG_LO_CYC+3 cycles after `pgood_i` falls. If `park_ack_i` is 1 during a cycle with `park_req_o` at 1, `park_req_o` drops on the next cycle and `int_rst_o` stays 1. The sequence never goes back to normal operation without passing through the internal reset.
- R5: `int_rst_o` stays 1 for as long as the qualified power-good level is low.
- R6: Once in internal reset, `int_rst_o` falls PG_HI_CYC+3 cycles after `pgood_i` returns high for good, provided the minimum internal reset time is over. A high pulse shorter than PG_HI_CYC cycles does not release it.
- R7: When the board output is released, it falls DELAY_CYC cycles after `int_rst_o` rises because of a power-fail event or an internal request.
- R8: Each hardware-driven low period of `ext_rst_n_o` lasts at least WIDTH_CYC cycles. The output rises one cycle after `int_rst_o` falls, or WIDTH_CYC cycles after it fell, whichever is later.
- R9: `sw_force_i` at 1 drives `ext_rst_n_o` to 0 with no clock delay and does not disturb `int_rst_o`.
- R10: Without an acknowledge, `park_req_o` stays 1 for exactly PARK_TO_CYC cycles, and the internal reset then begins.
- R11: A one-cycle `soft_rst_req_i` pulse, given while power-good is qualified, raises `int_rst_o` on the next cycle for INT_MIN_CYC cycles without any park request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running system clock |
| pon_sense_i | input | 1 | Power-on sense, high when all supplies are valid (asynchronous) |
| pgood_i | input | 1 | Power-good early warning, low before supplies drop (asynchronous) |
| park_ack_i | input | 1 | Park done acknowledge from the display-device controller |
| soft_rst_req_i | input | 1 | One-cycle request for a full internal reset from on-chip logic |
| sw_release_i | input | 1 | One-cycle software write that releases the board reset after power-up |
| sw_force_i | input | 1 | Software override, 1 holds the board reset low |
| park_req_o | output | 1 | Request to park the display device |
| int_rst_o | output | 1 | Internal full-chip reset, active high |
| ext_rst_n_o | output | 1 | Board reset output, active low |

## Verification
The assertions assume that `park_ack_i` only rises while a park is being requested. They also assume that `soft_rst_req_i` and `sw_release_i` are single-cycle pulses synchronous to the clock, and that `pgood_i` changes far less often than once per qualification window apart from deliberate glitches. The stimulus drives the acknowledge only in the cycle after `park_req_o` is seen high. It drives every software input for exactly one cycle. It shapes `pgood_i` as one low window, with at most one short high glitch inside it, and leaves enough idle time between windows for the board output to return high. The sweep covers every low-pulse length from one cycle to two past the qualification window. It alternates acknowledge and timeout, so each length is compared against closed-form expected cycle counts.

// File: rtl/pwrseq_pkg.sv
package pwrseq_pkg;

    // Main sequence states
    typedef enum logic [1:0] {
        SQ_RUN   = 2'd0,
        SQ_PARK  = 2'd1,
        SQ_RESET = 2'd2
    } seq_state_e;

    // Board reset output states
    typedef enum logic [1:0] {
        XR_BOOT = 2'd0,
        XR_RUN  = 2'd1,
        XR_HELD = 2'd2
    } xrst_state_e;

    // Status handed from the main sequence to the board-reset controller
    typedef struct packed {
        logic int_rst;
        logic park_req;
        logic hw_evt;
        logic idle;
    } seq_status_t;

    // Bits needed for a counter that reaches 'limit'
    function automatic int cnt_bits(input int limit);
        return (limit < 2) ? 1 : $clog2(limit + 1);
    endfunction

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/pwrseq_sync.sv
module pwrseq_sync #(
    parameter int N = 2
) (
    input  logic         clk,
    input  logic [N-1:0] d_i,
    output logic [N-1:0] q_o
);
    // Two-flop synchroniser per bit; deliberately not reset
    for (genvar i = 0; i < N; i++) begin : g_bit
        logic s1;
        logic s2;
        always_ff @(posedge clk) begin
            s1 <= d_i[i];
            s2 <= s1;
        end
        assign q_o[i] = s2;
    end
endmodule

// File: rtl/pwrseq_pg_qual.sv
module pwrseq_pg_qual
    import pwrseq_pkg::*;
#(
    parameter int LO_CYC = 8,
    parameter int HI_CYC = 64
) (
    input  logic clk,
    input  logic rst,
    input  logic pg_s_i,
    output logic ok_o
);
    localparam int MAXC = imax(LO_CYC, HI_CYC);
    localparam int CW   = cnt_bits(MAXC);
    localparam logic [CW-1:0] LO_LAST = CW'(LO_CYC - 1);
    localparam logic [CW-1:0] HI_LAST = CW'(HI_CYC - 1);
    localparam logic [CW-1:0] SAT     = CW'(MAXC);

    logic [CW-1:0] cnt_q;
    logic [CW-1:0] need_last;

    assign need_last = pg_s_i ? HI_LAST : LO_LAST;

    // Level flips only after the required run of differing samples
    always_ff @(posedge clk) begin
        if (rst) begin
            ok_o  <= 1'b0;
            cnt_q <= '0;
        end else if (pg_s_i == ok_o) begin
            cnt_q <= '0;
        end else if (cnt_q == need_last) begin
            ok_o  <= pg_s_i;
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // Independent run-length monitors for the checks below
    logic [CW-1:0] lo_run;
    logic [CW-1:0] hi_run;
    always_ff @(posedge clk) begin
        if (rst) begin
            lo_run <= '0;
            hi_run <= '0;
        end else begin
            lo_run <= pg_s_i ? '0 : ((lo_run == SAT) ? lo_run : lo_run + 1'b1);
            hi_run <= !pg_s_i ? '0 : ((hi_run == SAT) ? hi_run : hi_run + 1'b1);
        end
    end

    // R3
    glitch_reject_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(ok_o) |-> (lo_run >= CW'(LO_CYC)));

    // R6
    requal_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(ok_o) |-> (hi_run >= CW'(HI_CYC)));
endmodule

// File: rtl/pwrseq_fail_seq.sv
module pwrseq_fail_seq
    import pwrseq_pkg::*;
#(
    parameter int PARK_TO_CYC = 1000,
    parameter int INT_MIN_CYC = 16
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        pg_ok_i,
    input  logic        park_ack_i,
    input  logic        soft_req_i,
    output seq_status_t stat_o
);
    localparam int TW = cnt_bits(PARK_TO_CYC);
    localparam int HW = cnt_bits(INT_MIN_CYC);
    localparam logic [TW-1:0] T_LAST = TW'(PARK_TO_CYC - 1);
    localparam logic [HW-1:0] H_LAST = HW'(INT_MIN_CYC - 1);

    seq_state_e    st_q, st_d;
    logic [TW-1:0] tcnt_q;
    logic [HW-1:0] hcnt_q;

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            SQ_RUN: begin
                if (!pg_ok_i)        st_d = SQ_PARK;
                else if (soft_req_i) st_d = SQ_RESET;
            end
            SQ_PARK: begin
                if (park_ack_i || (tcnt_q == T_LAST)) st_d = SQ_RESET;
            end
            SQ_RESET: begin
                if (pg_ok_i && (hcnt_q == H_LAST)) st_d = SQ_RUN;
            end
            default: st_d = SQ_RESET;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= SQ_RESET;
            tcnt_q <= '0;
            hcnt_q <= '0;
        end else begin
            st_q   <= st_d;
            tcnt_q <= (st_q == SQ_PARK) ? tcnt_q + 1'b1 : '0;
            if (st_q != SQ_RESET)      hcnt_q <= '0;
            else if (hcnt_q != H_LAST) hcnt_q <= hcnt_q + 1'b1;
        end
    end

    assign stat_o.int_rst  = (st_q != SQ_RUN);
    assign stat_o.park_req = (st_q == SQ_PARK);
    assign stat_o.hw_evt   = (st_q == SQ_RUN) && (st_d != SQ_RUN);
    assign stat_o.idle     = (st_q == SQ_RUN);

    // R4
    park_then_reset_chk: assert property (@(posedge clk) disable iff (rst)
        (st_q == SQ_PARK) |=> (st_q != SQ_RUN));

    // R5
    pg_low_holds_chk: assert property (@(posedge clk) disable iff (rst)
        !pg_ok_i |=> stat_o.int_rst);

    // R11
    req_no_park_chk: assert property (@(posedge clk) disable iff (rst)
        (stat_o.idle && pg_ok_i && soft_req_i) |=> !stat_o.park_req);
endmodule

// File: rtl/pwrseq_ext_ctl.sv
module pwrseq_ext_ctl
    import pwrseq_pkg::*;
#(
    parameter int DELAY_CYC = 1250,
    parameter int WIDTH_CYC = 500000
) (
    input  logic clk,
    input  logic rst,
    input  logic pon_async_i,
    input  logic sw_release_i,
    input  logic sw_force_i,
    input  logic hw_evt_i,
    input  logic seq_idle_i,
    output logic ext_rst_n_o
);
    localparam int DW = cnt_bits(DELAY_CYC);
    localparam int WW = cnt_bits(WIDTH_CYC);
    localparam logic [DW-1:0] D_LAST = DW'(DELAY_CYC - 1);
    localparam logic [WW-1:0] W_LAST = WW'(WIDTH_CYC - 1);
    localparam logic [WW-1:0] W_FULL = WW'(WIDTH_CYC);

    xrst_state_e   st_q;
    logic [WW-1:0] wcnt_q;
    logic [DW-1:0] dcnt_q;
    logic          rel_q;
    logic          pend_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= XR_BOOT;
            wcnt_q <= W_LAST;
            dcnt_q <= '0;
            rel_q  <= 1'b0;
            pend_q <= 1'b0;
        end else begin
            unique case (st_q)
                XR_BOOT: begin
                    if (sw_release_i)   rel_q  <= 1'b1;
                    if (wcnt_q != '0)   wcnt_q <= wcnt_q - 1'b1;
                    if (rel_q && (wcnt_q == '0)) st_q <= XR_RUN;
                end
                XR_RUN: begin
                    rel_q <= 1'b0;
                    if (pend_q) begin
                        if (dcnt_q == D_LAST) begin
                            st_q   <= XR_HELD;
                            wcnt_q <= W_LAST;
                            pend_q <= 1'b0;
                        end else begin
                            dcnt_q <= dcnt_q + 1'b1;
                        end
                    end else if (hw_evt_i) begin
                        pend_q <= 1'b1;
                        dcnt_q <= '0;
                    end
                end
                XR_HELD: begin
                    if (wcnt_q != '0)    wcnt_q <= wcnt_q - 1'b1;
                    else if (seq_idle_i) st_q   <= XR_RUN;
                end
                default: st_q <= XR_BOOT;
            endcase
        end
    end

    // Power-on sense acts without any clock
    assign ext_rst_n_o = pon_async_i && (st_q == XR_RUN) && !sw_force_i;

    // Held-time monitor for the width check
    logic [WW-1:0] run_len;
    always_ff @(posedge clk) begin
        if (rst)                  run_len <= '0;
        else if (st_q != XR_HELD) run_len <= '0;
        else if (run_len != W_FULL) run_len <= run_len + 1'b1;
    end

    // R8
    min_width_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(st_q == XR_HELD) |-> ($past(run_len) >= W_LAST));

    // R2
    boot_hold_chk: assert property (@(posedge clk) disable iff (rst)
        ((st_q == XR_BOOT) && !rel_q) |=> (st_q == XR_BOOT));
endmodule

// File: rtl/pwr_rst_seq.sv
module pwr_rst_seq
    import pwrseq_pkg::*;
#(
    parameter int PG_LO_CYC   = 8,
    parameter int PG_HI_CYC   = 64,
    parameter int PARK_TO_CYC = 1000,
    parameter int INT_MIN_CYC = 16,
    parameter int DELAY_CYC   = 1250,
    parameter int WIDTH_CYC   = 500000
) (
    input  logic clk,
    input  logic pon_sense_i,
    input  logic pgood_i,
    input  logic park_ack_i,
    input  logic soft_rst_req_i,
    input  logic sw_release_i,
    input  logic sw_force_i,
    output logic park_req_o,
    output logic int_rst_o,
    output logic ext_rst_n_o
);
    logic [1:0]  sync_q;
    logic        pon_s;
    logic        pg_s;
    logic        rst;
    logic        pg_ok;
    seq_status_t stat;

    pwrseq_sync #(.N(2)) u_sync (
        .clk (clk),
        .d_i ({pgood_i, pon_sense_i}),
        .q_o (sync_q)
    );
    assign pon_s = sync_q[0];
    assign pg_s  = sync_q[1];
    assign rst   = !pon_s;

    pwrseq_pg_qual #(.LO_CYC(PG_LO_CYC), .HI_CYC(PG_HI_CYC)) u_qual (
        .clk    (clk),
        .rst    (rst),
        .pg_s_i (pg_s),
        .ok_o   (pg_ok)
    );

    pwrseq_fail_seq #(.PARK_TO_CYC(PARK_TO_CYC), .INT_MIN_CYC(INT_MIN_CYC)) u_seq (
        .clk        (clk),
        .rst        (rst),
        .pg_ok_i    (pg_ok),
        .park_ack_i (park_ack_i),
        .soft_req_i (soft_rst_req_i),
        .stat_o     (stat)
    );

    pwrseq_ext_ctl #(.DELAY_CYC(DELAY_CYC), .WIDTH_CYC(WIDTH_CYC)) u_ext (
        .clk          (clk),
        .rst          (rst),
        .pon_async_i  (pon_sense_i),
        .sw_release_i (sw_release_i),
        .sw_force_i   (sw_force_i),
        .hw_evt_i     (stat.hw_evt),
        .seq_idle_i   (stat.idle),
        .ext_rst_n_o  (ext_rst_n_o)
    );

    assign park_req_o = stat.park_req && !rst;
    assign int_rst_o  = stat.int_rst || rst;

    // R9
    force_low_chk: assert property (@(posedge clk) disable iff (rst)
        sw_force_i |-> !ext_rst_n_o);
endmodule

// File: tb/sim_pwr_rst_seq.sv
module sim_pwr_rst_seq;
    localparam int LO = 4;
    localparam int HI = 6;
    localparam int PT = 5;
    localparam int IM = 3;
    localparam int DL = 7;
    localparam int WD = 12;

    logic clk = 1'b0;
    logic pon = 1'b0, pg = 1'b0, ack = 1'b0, sreq = 1'b0, srel = 1'b0, sforce = 1'b0;
    logic park, irst, xrst_n;
    int   n_total = 0, n_fail = 0;
    bit   finished = 1'b0;

    always #2 clk = ~clk;

    pwr_rst_seq #(
        .PG_LO_CYC(LO), .PG_HI_CYC(HI), .PARK_TO_CYC(PT),
        .INT_MIN_CYC(IM), .DELAY_CYC(DL), .WIDTH_CYC(WD)
    ) u0 (
        .clk(clk), .pon_sense_i(pon), .pgood_i(pg), .park_ack_i(ack),
        .soft_rst_req_i(sreq), .sw_release_i(srel), .sw_force_i(sforce),
        .park_req_o(park), .int_rst_o(irst), .ext_rst_n_o(xrst_n)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_total++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wrap_up();
        if (!finished) begin
            finished = 1'b1;
            $display("%0d/%0d checks passed", n_total - n_fail, n_total);
            $finish;
        end
    endtask

    task automatic step(input int k);
        repeat (k) @(negedge clk);
    endtask

    // One pgood / request episode, checked against closed-form cycle counts
    task automatic run_seq(input int L, input bit use_ack, input int gs, input int gl,
                           input bit req, input string fall_tag);
        int fpark = -1, pcnt = 0, fint = -1, ffall = -1, fext = -1, frise = -1;
        int start, plen, er, nr, eh, rel;
        bit event_exp;
        pg   = (L > 0) ? 1'b0 : 1'b1;
        sreq = req;
        for (int n = 1; n <= 90; n++) begin
            step(1);
            if (park && fpark < 0) fpark = n;
            if (park) pcnt++;
            if (irst && fint < 0) fint = n;
            if (fint >= 0 && !irst && ffall < 0) ffall = n;
            if (!xrst_n && fext < 0) fext = n;
            if (fext >= 0 && xrst_n && frise < 0) frise = n;
            sreq = 1'b0;
            if (use_ack && park && !ack && pcnt == 1) ack = 1'b1;
            else ack = 1'b0;
            pg = !((n < L) && !((n >= gs) && (n < gs + gl)));
        end
        event_exp = req || (L >= LO);
        if (!event_exp) begin
            chk(fint < 0 && fpark < 0 && fext < 0, "R3", fint, -1);
        end else begin
            if (req) begin
                start = 1; plen = 0; er = 1; nr = 1 + IM;
                chk(fpark < 0, "R11", fpark, -1);
            end else begin
                start = LO + 3;
                plen  = use_ack ? 1 : PT;
                er    = start + plen;
                nr    = (er + IM > L + 3 + HI) ? er + IM : L + 3 + HI;
                chk(fpark == start, "R4", fpark, start);
                chk(pcnt == plen, use_ack ? "R4" : "R10", pcnt, plen);
            end
            eh  = start + DL;
            rel = (eh + WD > nr + 1) ? eh + WD : nr + 1;
            chk(fint == start, "R4", fint, start);
            chk(ffall == nr, fall_tag, ffall, nr);
            chk(fext == eh, "R7", fext, eh);
            chk(frise == rel, "R8", frise, rel);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_total++;
        n_fail++;
        $display("FAIL watchdog: actual 1 expected 0");
        wrap_up();
    end

    initial begin
        int cnt;
        bit stayed;
        step(4);
        // R1 reset state
        chk(xrst_n == 1'b0, "R1", xrst_n, 0);
        chk(irst == 1'b1, "R1", irst, 1);
        chk(park == 1'b0, "R1", park, 0);

        // First power-up: requalification of pgood (R6)
        pon = 1'b1; pg = 1'b1;
        cnt = 0;
        do begin step(1); cnt++; end while (irst && cnt < 50);
        chk(cnt == HI + 3, "R6", cnt, HI + 3);

        // R2: held without a release write
        stayed = 1'b1;
        for (int i = 0; i < 3 * WD; i++) begin
            step(1);
            if (xrst_n) stayed = 1'b0;
        end
        chk(stayed, "R2", xrst_n, 0);
        srel = 1'b1; step(1); srel = 1'b0;
        chk(xrst_n == 1'b0, "R2", xrst_n, 0);
        step(1);
        chk(xrst_n == 1'b1, "R2", xrst_n, 1);

        // R9 software override
        sforce = 1'b1; #1;
        chk(xrst_n == 1'b0, "R9", xrst_n, 0);
        step(3);
        chk(irst == 1'b0, "R9", irst, 0);
        sforce = 1'b0; #1;
        chk(xrst_n == 1'b1, "R9", xrst_n, 1);
        step(1);

        // R3/R4/R7/R8 sweep over low-pulse length, alternating ack and timeout
        for (int L = 1; L <= LO + 2; L++) run_seq(L, L[0], 0, 0, 1'b0, "R6");
        // R5 / R10: long low, no acknowledge
        run_seq(40, 1'b0, 0, 0, 1'b0, "R5");
        // R6: short high glitch inside the low window does not release
        run_seq(40, 1'b1, 20, HI - 1, 1'b0, "R6");
        // R11: internal request
        run_seq(0, 1'b0, 0, 0, 1'b1, "R11");

        // R1: immediate assertion on power-on sense loss
        chk(xrst_n == 1'b1, "R1", xrst_n, 1);
        pon = 1'b0; #1;
        chk(xrst_n == 1'b0, "R1", xrst_n, 0);
        step(4);
        chk(irst == 1'b1 && park == 1'b0, "R1", irst, 1);

        // R2: early release remembered, minimum width still applies
        pon = 1'b1;
        cnt = 0;
        do begin
            step(1); cnt++;
            srel = (cnt == 2);
        end while (!xrst_n && cnt < 60);
        srel = 1'b0;
        chk(cnt == WD + 2, "R2", cnt, WD + 2);

        wrap_up();
    end
endmodule